// File: doc/BRIEF.md
# Mod-3 Channel Hash Inverter

This block works out the two high-order port-address bits, called m here, that a memory controller needs when a group of three or six channels spreads addresses with a modulo-3 hash. The hash is taken from the address itself. The block is given three things: a real address that already carries any inserted group-ID bit, the group ID, and a flag that marks a six-channel group. From these it finds the m value for which the forward hash lands on the residue that the group ID and the low select bits call for.

Residues modulo 3 are kept as one-hot 3-bit words. Adding to a residue is a right rotation of the word, and subtracting is a left rotation. Three 2-bit fields of the address are folded into one residue, the address residue. The group ID and the select bits give a second residue, the target residue. m is the number of single left steps that carry the target residue onto the address residue.

The block compares all three candidate rotations in parallel in one combinational stage. It then registers the answer together with a valid flag.

Top module: `mod3_msb_solver`

## Requirements
- R1: A 2-bit value is encoded as a one-hot residue word: 0 gives 3'b100, 1 gives 3'b010, 2 gives 3'b001, and 3 gives 3'b100 because its residue is 0. The group ID is encoded as its own value modulo 3.
- R2: The address residue is built in three steps. It starts as the encoding of addr[16:15]. It is then rotated right by addr[18:17] and then rotated right by addr[20:19]. One right step moves 3'b100 to 3'b010, which adds 1 to the residue. A rotation count of 3 leaves the word unchanged.
- R3: The target residue is the encoding of the group ID rotated left by addr[8:7]. One left step moves 3'b010 to 3'b100, which subtracts 1 from the residue.
- R4: When six_chan is 1, bit 0 of the group ID is cleared and addr[7] is treated as 0 before the target residue is formed.
- R5: m_bits is the count (0, 1 or 2) of single left rotations of the target residue that make it equal the address residue. Rotating the address residue right by m_bits therefore gives back the target residue. m_bits is never 3.
- R6: When in_valid is high at a rising clock edge, out_valid is 1 after that edge and m_bits holds the result for the inputs sampled at that edge. Otherwise out_valid is 0 after the edge.
- R7: While in_valid is low, m_bits keeps its previous value whatever the other inputs do.
- R8: A synchronous active-high rst makes out_valid 0 and m_bits 0.
- R9: Address bits other than [20:15] and [8:7] have no effect on m_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| addr | input | ADDR_W (48) | Partly built real address, right-justified |
| grp_id | input | GID_W (3) | Group ID |
| six_chan | input | 1 | Group has six channels |
| out_valid | output | 1 | m_bits was updated at the last edge |
| m_bits | output | 2 | Recovered high port-address bits |

## Verification
The checker assumes that addr, grp_id and six_chan are stable and known at every edge where in_valid is high. It also assumes that rst is deasserted at least one edge before any property looks one cycle back. The bench drives all inputs at the falling edge and holds them for the whole cycle. It sweeps every combination of the six hash-field bits, the two select bits, all eight group IDs and both values of the six-channel flag. Random values go into the ignored address bits. A separate check toggles only those ignored bits and expects the same m_bits.

// File: rtl/m3s_pkg.sv
package m3s_pkg;

    typedef logic [2:0] res_t;

    localparam int FIELD_W       = 2;
    localparam int N_HASH_FIELDS = 3;
    localparam int HASH_LSB      = 15;
    localparam int HASH_MSB      = HASH_LSB + FIELD_W * N_HASH_FIELDS - 1;
    localparam int SEL_LSB       = 7;
    localparam int SEL_MSB       = SEL_LSB + FIELD_W - 1;
    localparam int N_ROT         = 3;

    localparam res_t RES_ZERO = 3'b100;
    localparam res_t RES_ONE  = 3'b010;
    localparam res_t RES_TWO  = 3'b001;

    typedef struct packed {
        res_t addr_res;
        res_t tgt_res;
    } hash_pair_t;

    typedef struct packed {
        logic       vld;
        logic [1:0] m;
    } result_t;

    function automatic res_t enc_mod(input logic [7:0] v);
        case (v % 8'd3)
            8'd0:    return RES_ZERO;
            8'd1:    return RES_ONE;
            default: return RES_TWO;
        endcase
    endfunction

    function automatic res_t rot_r1(input res_t v);
        return {v[0], v[2:1]};
    endfunction

    function automatic res_t rot_l1(input res_t v);
        return {v[1:0], v[2]};
    endfunction

    function automatic res_t rot_r(input res_t v, input logic [1:0] n);
        res_t t = v;
        for (int i = 0; i < N_ROT - 1; i++)
            if (i < int'(n) % N_ROT) t = rot_r1(t);
        return t;
    endfunction

    function automatic res_t rot_l(input res_t v, input logic [1:0] n);
        res_t t = v;
        for (int i = 0; i < N_ROT - 1; i++)
            if (i < int'(n) % N_ROT) t = rot_l1(t);
        return t;
    endfunction

endpackage

// File: rtl/m3s_addr_residue.sv
module m3s_addr_residue
    import m3s_pkg::*;
#(
    parameter int NF = N_HASH_FIELDS
) (
    input  logic [NF*FIELD_W-1:0] fields,
    output res_t                  res
);
    res_t stage [NF];

    assign stage[0] = enc_mod(8'(fields[FIELD_W-1:0]));

    for (genvar k = 1; k < NF; k++) begin : g_chain
        assign stage[k] = rot_r(stage[k-1], fields[k*FIELD_W +: FIELD_W]);
    end

    assign res = stage[NF-1];
endmodule

// File: rtl/m3s_target_residue.sv
module m3s_target_residue
    import m3s_pkg::*;
#(
    parameter int GID_W = 3
) (
    input  logic [GID_W-1:0]   grp_id,
    input  logic [FIELD_W-1:0] sel,
    input  logic               six_chan,
    output res_t               res
);
    localparam logic [GID_W-1:0] GID_HI_MASK = ~GID_W'(1);

    logic [GID_W-1:0]   gid_eff;
    logic [FIELD_W-1:0] sel_eff;

    always_comb begin
        gid_eff = six_chan ? (grp_id & GID_HI_MASK) : grp_id;
        sel_eff = six_chan ? {sel[FIELD_W-1], 1'b0} : sel;
        res     = rot_l(enc_mod(8'(gid_eff)), sel_eff);
    end
endmodule

// File: rtl/m3s_rot_match.sv
module m3s_rot_match
    import m3s_pkg::*;
(
    input  hash_pair_t pair,
    output logic [1:0] m
);
    logic [N_ROT-1:0] hit;

    for (genvar k = 0; k < N_ROT; k++) begin : g_cand
        assign hit[k] = (rot_l(pair.tgt_res, 2'(k)) == pair.addr_res);
    end

    always_comb begin
        m = 2'd0;
        for (int k = N_ROT - 1; k > 0; k--)
            if (hit[k]) m = 2'(k);
    end
endmodule

// File: rtl/mod3_msb_solver.sv
module mod3_msb_solver
    import m3s_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int GID_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GID_W-1:0]  grp_id,
    input  logic              six_chan,
    output logic              out_valid,
    output logic [1:0]        m_bits
);
    hash_pair_t pair;
    logic [1:0] m_next;
    result_t    res_q;

    m3s_addr_residue #(.NF(N_HASH_FIELDS)) u_addr_res (
        .fields (addr[HASH_MSB:HASH_LSB]),
        .res    (pair.addr_res)
    );

    m3s_target_residue #(.GID_W(GID_W)) u_tgt_res (
        .grp_id   (grp_id),
        .sel      (addr[SEL_MSB:SEL_LSB]),
        .six_chan (six_chan),
        .res      (pair.tgt_res)
    );

    m3s_rot_match u_match (
        .pair (pair),
        .m    (m_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= in_valid;
            if (in_valid) res_q.m <= m_next;
        end
    end

    assign out_valid = res_q.vld;
    assign m_bits    = res_q.m;
endmodule

// File: rtl/mod3_msb_solver_chk.sv
module mod3_msb_solver_chk
    import m3s_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int GID_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] addr,
    input logic [GID_W-1:0]  grp_id,
    input logic              six_chan,
    input logic              out_valid,
    input logic [1:0]        m_bits
);
    function automatic logic [1:0] res_val(input res_t r);
        return r[2] ? 2'd0 : (r[1] ? 2'd1 : 2'd2);
    endfunction

    function automatic logic [1:0] fwd_addr(input logic [ADDR_W-1:0] a);
        return 2'((int'(a[16:15]) + int'(a[18:17]) + int'(a[20:19])) % 3);
    endfunction

    function automatic logic [1:0] tgt_val(input logic [GID_W-1:0] g,
                                           input logic [1:0] s,
                                           input logic six);
        int gv = six ? (int'(g) & ~1) : int'(g);
        int sv = six ? (int'(s) & 2) : int'(s);
        return 2'(((gv % 3) - (sv % 3) + 3) % 3);
    endfunction

    // R8
    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && m_bits == 2'd0));

    // R6
    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(m_bits));

    // R5
    p_m_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (m_bits != 2'd3));

    // R5: forward hash with recovered m reaches the target residue
    p_forward_hash_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (2'((int'($past(fwd_addr(addr))) + int'(m_bits)) % 3)
                      == $past(tgt_val(grp_id, addr[8:7], six_chan))));

    // R1
    initial begin
        a_enc_three_r1: assert (res_val(enc_mod(8'd3)) == 2'd0);
    end
endmodule

bind mod3_msb_solver mod3_msb_solver_chk #(.ADDR_W(ADDR_W), .GID_W(GID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .addr      (addr),
    .grp_id    (grp_id),
    .six_chan  (six_chan),
    .out_valid (out_valid),
    .m_bits    (m_bits)
);

// File: tb/mod3_msb_solver_tb_top.sv
module mod3_msb_solver_tb_top;
    localparam int ADDR_W = 48;
    localparam int GID_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [GID_W-1:0]  grp_id = '0;
    logic              six_chan = 1'b0;
    logic              out_valid;
    logic [1:0]        m_bits;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mod3_msb_solver #(.ADDR_W(ADDR_W), .GID_W(GID_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .addr      (addr),
        .grp_id    (grp_id),
        .six_chan  (six_chan),
        .out_valid (out_valid),
        .m_bits    (m_bits)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_m(input logic [ADDR_W-1:0] a,
                                 input int g, input bit six);
        int r2 = (int'(a[16:15]) + int'(a[18:17]) + int'(a[20:19])) % 3;
        int gv = six ? (g & 6) : g;
        int sv = six ? (int'(a[8:7]) & 2) : int'(a[8:7]);
        int r3 = ((gv % 3) - (sv % 3) + 3) % 3;
        return (r3 - r2 + 3) % 3;
    endfunction

    function automatic logic [ADDR_W-1:0] rand_addr();
        return {$urandom, $urandom} & ADDR_W'(48'hFFFF_FFFF_FFFF);
    endfunction

    // drives at a falling edge, samples at the next falling edge
    task automatic apply(input logic [ADDR_W-1:0] a, input int g,
                         input bit six, output int got);
        in_valid = 1'b1;
        addr     = a;
        grp_id   = GID_W'(g);
        six_chan = six;
        @(negedge clk);
        check("R6 out_valid", int'(out_valid), 1);
        got = int'(m_bits);
    endtask

    initial begin
        int got;
        int exp;
        int got2;
        logic [ADDR_W-1:0] a;
        repeat (3) @(negedge clk);
        check("R8 out_valid after reset", int'(out_valid), 0);
        check("R8 m_bits after reset", int'(m_bits), 0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5: full sweep of hash fields, select, group, six flag
        for (int hf = 0; hf < 64; hf++) begin
            for (int sl = 0; sl < 4; sl++) begin
                for (int g = 0; g < 8; g++) begin
                    for (int six = 0; six < 2; six++) begin
                        a = rand_addr();
                        a[20:15] = 6'(hf);
                        a[8:7]   = 2'(sl);
                        exp = exp_m(a, g, six[0]);
                        apply(a, g, six[0], got);
                        check(six ? "R4 six-channel m" : "R2/R3 m", got, exp);
                    end
                end
            end
        end

        // R1: value 3 in the first field acts as residue 0
        a = '0; a[16:15] = 2'd3;
        apply(a, 0, 1'b0, got);
        check("R1 field value 3 as residue 0", got, 0);
        a = '0; a[16:15] = 2'd2;
        apply(a, 0, 1'b0, got);
        check("R1 field value 2", got, 1);

        // R5: forward check, r2 + m == r3 (mod 3)
        a = '0; a[20:15] = 6'b01_10_01; a[8:7] = 2'd1;
        apply(a, 5, 1'b0, got);
        check("R5 forward hash", ((int'(a[16:15]) + int'(a[18:17])
              + int'(a[20:19])) % 3 + got) % 3, ((5 % 3) - 1 + 3) % 3);
        check("R5 range", int'(got != 3), 1);

        // R9: ignored bits toggled only
        a = '0; a[20:15] = 6'b11_01_10; a[8:7] = 2'd2;
        apply(a, 4, 1'b0, got);
        a = a | ~((ADDR_W'(6'h3F) << 15) | (ADDR_W'(2'h3) << 7));
        apply(a, 4, 1'b0, got2);
        check("R9 ignored bits", got2, got);

        // R7: idle cycles hold m_bits, out_valid drops (R6)
        in_valid = 1'b0;
        addr     = ~addr;
        grp_id   = grp_id + 1'b1;
        six_chan = 1'b1;
        @(negedge clk);
        check("R6 out_valid idle", int'(out_valid), 0);
        check("R7 hold", int'(m_bits), got2);
        addr = rand_addr();
        @(negedge clk);
        check("R7 hold second idle", int'(m_bits), got2);

        // R8: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run out_valid", int'(out_valid), 0);
        check("R8 mid-run m_bits", int'(m_bits), 0);
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule